// File: doc/BRIEF.md
# Register-Triggered SPI Flash Command Engine

This block is an SPI master that carries out one whole serial-flash transaction each time the host writes its mode register. The host sees a window of eight byte-wide registers. These hold a command byte, the mode/trigger byte, two low address bytes and four data bytes. The four data bytes serve as the source for written data and as the destination for returned data. Reads of the window are combinational. Writes are single-cycle strobes, and the window accepts them only while the engine is idle.

The upper nibble of the mode byte selects one of eleven transaction shapes. Each shape combines a command byte, a three-byte address, an engine-generated dummy byte, and up to four data bytes written or read. The lower nibble becomes address bits 19:16, so the reachable address space is 1 MiB. The serial side runs in SPI mode 0 with a clock derived from the system clock. The host-side window is a plain register strobe interface with no back-pressure: a write presented while the engine is busy is dropped, and `busy` tells the host when to poll the returned data.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `busy` is 0 and all eight window registers read 0x00.
- R2: While `busy` is 0, a write with `host_we`=1 stores `host_wdata` at offset `host_addr`. `host_rdata` always shows the byte at `host_addr` in the same cycle. Offsets: 0 command, 1 mode, 2 address bits 15:8, 3 address bits 7:0, 4..7 data bytes 0..3.
- R3: A write to offset 1 whose bits 7:4 hold a value from 1 to 11 starts a transaction. On the next clock `busy` is 1 and `spi_cs_n` is 0.
- R4: A write to offset 1 whose bits 7:4 hold 0 or 12..15 stores the byte but starts nothing. `busy` stays 0 and `spi_cs_n` stays 1.
- R5: Any window write presented while `busy` is 1 is ignored and leaves the registers unchanged.
- R6: The serial link is SPI mode 0, MSB first. `spi_sck` idles low, MOSI changes only while `spi_sck` is low, MISO is sampled on the rising edge, and each `spi_sck` phase lasts `CLK_DIV` clocks.
- R7: Every transaction begins with the command byte (offset 0). Modes 4..11 follow it with three address bytes: {4'h0, mode[3:0]}, then offset 2, then offset 3.
- R8: Write shapes send data from offset 4 upward after their header. Mode 2 sends the command and 1 byte, mode 5 sends the address and 1 byte, and mode 6 sends the address and 4 bytes. Mode 1 sends the command only, and mode 4 sends the command and address only.
- R9: Read shapes shift in bytes while MOSI sends 0x00, and store them at offsets 4, 5, 6, 7 in arrival order. Mode 3 reads 2 bytes after the command with no address. Modes 8..11 read (mode − 7) bytes after the address. Offsets that are not read keep their values.
- R10: Mode 7 sends one 0x00 dummy byte after the address and then reads 4 bytes. The dummy-byte slot is not stored.
- R11: `spi_cs_n` stays low across every byte of a transaction with no gap. It rises, and `busy` falls, on the clock edge that ends the last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Window write strobe |
| host_addr | input | 3 | Window offset |
| host_wdata | input | 8 | Window write data |
| host_rdata | output | 8 | Window read data at `host_addr` |
| busy | output | 1 | Transaction in progress |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |

## Verification
The bench builds the engine with `CLK_DIV`=2. This keeps each byte to 32 clocks, which makes it cheap to sweep all sixteen mode nibbles under three register patterns. A behavioural SPI device in the bench logs every MOSI byte and answers with a computed MISO stream. The sweep therefore reaches every transaction shape, the rejection of every illegal nibble, and every read-byte count into each data offset. A dedicated run issues writes in mid-transaction to show that they are dropped.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int WIN_BYTES = 8;
  localparam int DATA_BASE = 4;

  typedef struct packed {
    logic       legal;
    logic       has_addr;
    logic       has_dummy;
    logic [2:0] n_wr;
    logic [2:0] n_rd;
  } shape_t;

  function automatic shape_t decode_shape(input logic [3:0] m);
    shape_t s;
    s = '0;
    case (m)
      4'd1: s.legal = 1'b1;
      4'd2: begin s.legal = 1'b1; s.n_wr = 3'd1; end
      4'd3: begin s.legal = 1'b1; s.n_rd = 3'd2; end
      4'd4: begin s.legal = 1'b1; s.has_addr = 1'b1; end
      4'd5: begin s.legal = 1'b1; s.has_addr = 1'b1; s.n_wr = 3'd1; end
      4'd6: begin s.legal = 1'b1; s.has_addr = 1'b1; s.n_wr = 3'd4; end
      4'd7: begin
        s.legal = 1'b1; s.has_addr = 1'b1; s.has_dummy = 1'b1; s.n_rd = 3'd4;
      end
      4'd8, 4'd9, 4'd10, 4'd11: begin
        s.legal = 1'b1; s.has_addr = 1'b1; s.n_rd = 3'(m - 4'd7);
      end
      default: s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_we,
  input  logic [2:0]             host_addr,
  input  logic [7:0]             host_wdata,
  output logic [7:0]             host_rdata,
  input  logic                   busy,
  input  logic                   rx_we,
  input  logic [1:0]             rx_idx,
  input  logic [7:0]             rx_byte,
  output logic                   start,
  output logic [8*WIN_BYTES-1:0] regs_flat
);

  logic [7:0] win [WIN_BYTES];
  logic       accept;

  assign accept = host_we && !busy;
  assign start  = accept && (host_addr == 3'd1) && decode_shape(host_wdata[7:4]).legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < WIN_BYTES; k++) win[k] <= 8'h00;
    end else if (accept) begin
      win[host_addr] <= host_wdata;
    end else if (rx_we) begin
      win[DATA_BASE + int'(rx_idx)] <= rx_byte;
    end
  end

  assign host_rdata = win[host_addr];

  for (genvar g = 0; g < WIN_BYTES; g++) begin : g_flat
    assign regs_flat[8*g +: 8] = win[g];
  end

  // R5: header registers are frozen against host writes during a transaction
  a_r5_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we) |=> $stable(regs_flat[31:0]));

  // R4: an illegal mode nibble never raises busy
  a_r4_illegal_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !busy && host_addr == 3'd1 && !decode_shape(host_wdata[7:4]).legal)
      |=> !busy);

endmodule

// File: rtl/spi_cmd_clkdiv.sv
module spi_cmd_clkdiv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [3:0]             start_mode,
  input  logic                   tick,
  input  logic [8*WIN_BYTES-1:0] regs_flat,
  input  logic                   spi_miso,
  output logic                   busy,
  output logic                   spi_cs_n,
  output logic                   spi_sck,
  output logic                   spi_mosi,
  output logic                   rx_we,
  output logic [1:0]             rx_idx,
  output logic [7:0]             rx_byte
);

  shape_t     shp;
  logic [3:0] byte_idx, nidx, base, total, rd_from, woff;
  logic [2:0] bit_cnt;
  logic [7:0] tx_sh, rx_sh, nxt_byte;
  logic       last_bit, is_rd;

  assign nidx    = byte_idx + 4'd1;
  assign base    = 4'd1 + (shp.has_addr ? 4'd3 : 4'd0) + {3'b000, shp.has_dummy};
  assign rd_from = base + {1'b0, shp.n_wr};
  assign total   = rd_from + {1'b0, shp.n_rd};
  assign woff    = nidx - base;
  assign is_rd   = (byte_idx >= rd_from);

  always_comb begin
    nxt_byte = 8'h00;
    if (shp.has_addr && nidx <= 4'd3) begin
      case (nidx[1:0])
        2'd1:    nxt_byte = {4'h0, regs_flat[11:8]};
        2'd2:    nxt_byte = regs_flat[23:16];
        default: nxt_byte = regs_flat[31:24];
      endcase
    end else if (nidx >= base && woff < {1'b0, shp.n_wr}) begin
      nxt_byte = regs_flat[8*(DATA_BASE + int'(woff[1:0])) +: 8];
    end
  end

  assign last_bit = busy && tick && spi_sck && (bit_cnt == 3'd7);
  assign rx_we    = last_bit && is_rd;
  assign rx_idx   = 2'(byte_idx - rd_from);
  assign rx_byte  = rx_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      spi_cs_n <= 1'b1;
      spi_sck  <= 1'b0;
      shp      <= '0;
      byte_idx <= '0;
      bit_cnt  <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      spi_cs_n <= 1'b0;
      spi_sck  <= 1'b0;
      shp      <= decode_shape(start_mode);
      byte_idx <= '0;
      bit_cnt  <= '0;
      tx_sh    <= regs_flat[7:0];
    end else if (busy && tick) begin
      if (!spi_sck) begin
        spi_sck <= 1'b1;
        rx_sh   <= {rx_sh[6:0], spi_miso};
      end else begin
        spi_sck <= 1'b0;
        if (bit_cnt == 3'd7) begin
          if (nidx == total) begin
            busy     <= 1'b0;
            spi_cs_n <= 1'b1;
          end else begin
            byte_idx <= nidx;
            tx_sh    <= nxt_byte;
            bit_cnt  <= '0;
          end
        end else begin
          tx_sh   <= {tx_sh[6:0], 1'b0};
          bit_cnt <= bit_cnt + 3'd1;
        end
      end
    end
  end

  assign spi_mosi = spi_cs_n ? 1'b0 : tx_sh[7];

  // R6: clock parks low outside a transaction
  a_r6_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R6: data is held steady across the high phase of the serial clock
  a_r6_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  // R11: chip select tracks the busy flag exactly
  a_r11_cs_matches_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !spi_cs_n);

  // R3: a start selects the device on the next clock
  a_r3_start_selects: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!spi_cs_n && busy));

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic [2:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       busy,
  output logic       spi_cs_n,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso
);

  logic                   start, tick, rx_we;
  logic [1:0]             rx_idx;
  logic [7:0]             rx_byte;
  logic [8*WIN_BYTES-1:0] regs_flat;

  spi_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
    .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte),
    .start(start), .regs_flat(regs_flat)
  );

  spi_cmd_clkdiv #(.DIV(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .en(busy), .tick(tick)
  );

  spi_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_mode(host_wdata[7:4]),
    .tick(tick), .regs_flat(regs_flat), .spi_miso(spi_miso), .busy(busy),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte)
  );

endmodule

// File: tb/spi_cmd_engine_bench.sv
module spi_cmd_engine_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       busy, spi_cs_n, spi_sck, spi_mosi;
  logic       spi_miso = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  spi_cmd_engine #(.CLK_DIV(2)) u_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // behavioural flash device
  logic [7:0] seed = 8'h00;
  logic [7:0] dev_bytes [16];
  logic [7:0] dev_cur = 8'h00;
  int         dev_bits = 0;
  int         cs_falls = 0;

  function automatic logic [7:0] resp(input int k, input logic [7:0] s);
    return 8'h3C ^ 8'(k * 29) ^ s;
  endfunction

  function automatic logic resp_bit(input int n, input logic [7:0] s);
    logic [7:0] b;
    b = resp(n / 8, s);
    return b[7 - (n % 8)];
  endfunction

  always @(negedge spi_cs_n) begin
    dev_bits = 0;
    cs_falls = cs_falls + 1;
    spi_miso = resp_bit(0, seed);
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    dev_cur  = {dev_cur[6:0], spi_mosi};
    dev_bits = dev_bits + 1;
    if (dev_bits % 8 == 0 && dev_bits <= 128) dev_bytes[dev_bits/8 - 1] = dev_cur;
  end

  always @(negedge spi_sck) if (!spi_cs_n) spi_miso = resp_bit(dev_bits, seed);

  always @(posedge clk) cycles <= cycles + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic run_txn(input logic [3:0] m, input int pat);
    logic [7:0] cmd, ahi, alo, mb, rb;
    logic [7:0] dat [4];
    logic [7:0] exp_bytes [16];
    int         n_exp, n_wr, n_rd, falls0, rd_start;
    bit         legal, has_addr, dummy;
    cmd = 8'h05 + 8'(pat * 17) + {4'h0, m};
    ahi = 8'hA1 ^ 8'(pat * 3);
    alo = 8'h5E + 8'(pat);
    mb  = {m, 4'(pat * 5 + 3)};
    for (int k = 0; k < 4; k++) dat[k] = 8'h80 + 8'(16 * pat + 4 * k + m);
    seed = 8'(m * 11 + pat);
    legal    = (m >= 1 && m <= 11);
    has_addr = (m >= 4 && m <= 11);
    dummy    = (m == 7);
    n_wr = (m == 2 || m == 5) ? 1 : (m == 6) ? 4 : 0;
    n_rd = (m == 3) ? 2 : (m == 7) ? 4 : (m >= 8 && m <= 11) ? int'(m) - 7 : 0;
    n_exp = 0;
    exp_bytes[n_exp++] = cmd;
    if (has_addr) begin
      exp_bytes[n_exp++] = {4'h0, mb[3:0]};
      exp_bytes[n_exp++] = ahi;
      exp_bytes[n_exp++] = alo;
    end
    if (dummy) exp_bytes[n_exp++] = 8'h00;
    for (int k = 0; k < n_wr; k++) exp_bytes[n_exp++] = dat[k];
    rd_start = n_exp;
    for (int k = 0; k < n_rd; k++) exp_bytes[n_exp++] = 8'h00;

    host_write(3'd0, cmd);
    host_write(3'd2, ahi);
    host_write(3'd3, alo);
    for (int k = 0; k < 4; k++) host_write(3'(4 + k), dat[k]);
    falls0 = cs_falls;
    host_write(3'd1, mb);
    if (legal) check("R3 busy after start", {31'd0, busy}, 32'd1);
    else       check("R4 no start on illegal mode", {31'd0, busy}, 32'd0);
    wait_idle();
    @(negedge clk);
    check(legal ? "R11 single selection" : "R4 chip select untouched",
          cs_falls - falls0, legal ? 1 : 0);
    check("R6 idle lines", {30'd0, spi_cs_n, spi_sck}, 32'b10);
    if (legal) begin
      check("R11 byte count", dev_bits, n_exp * 8);
      for (int k = 0; k < n_exp; k++)
        check(k == 0 ? "R7 command byte" : (k < 4 && has_addr) ? "R7 address byte" :
              (dummy && k == 4) ? "R10 dummy byte" :
              (k >= rd_start) ? "R9 mosi zero in read" : "R8 write data byte",
              dev_bytes[k], exp_bytes[k]);
    end
    host_read(3'd1, rb);
    check("R2 mode readback", rb, mb);
    for (int k = 0; k < 4; k++) begin
      host_read(3'(4 + k), rb);
      if (k < n_rd) check(dummy ? "R10 read data" : "R9 read data", rb, resp(rd_start + k, seed));
      else          check("R9 untouched data", rb, dat[k]);
    end
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] rb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset lines", {29'd0, spi_cs_n, spi_sck, busy}, 32'b100);
    for (int a = 0; a < 8; a++) begin
      host_read(3'(a), rb);
      check("R1 reset register", rb, 8'h00);
    end

    for (int pat = 0; pat < 3; pat++)
      for (int m = 0; m < 16; m++) run_txn(4'(m), pat);

    // R5: writes during a transaction are dropped
    seed = 8'h77;
    host_write(3'd0, 8'h0B);
    host_write(3'd1, 8'hB2);
    @(negedge clk);
    host_we = 1'b1; host_addr = 3'd0; host_wdata = 8'hEE;
    @(negedge clk);
    host_addr = 3'd2; host_wdata = 8'h99;
    @(negedge clk);
    host_addr = 3'd1; host_wdata = 8'h10;
    @(negedge clk);
    host_we = 1'b0;
    wait_idle();
    @(negedge clk);
    host_read(3'd0, rb);
    check("R5 command kept", rb, 8'h0B);
    host_read(3'd1, rb);
    check("R5 mode kept", rb, 8'hB2);
    check("R5 one transaction only", {31'd0, busy}, 32'd0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule